// File: doc/BRIEF.md
# Hot-plug interrupt locator aggregator

This block collects the event state of up to 31 hot-plug slots, plus a command-completion flag, into one 32-bit locator word and a single interrupt. Each slot owns a small register word. The low byte holds five event latches: presence change, isolated fault, attention button, latch-lever change and connected fault. Hardware sets these latches through event inputs, and software clears them by writing ones. The second byte is a seven-bit mask. Only its low five bits gate the interrupt. The upper two bits are kept for error-report masking and have no effect here.

A global control word holds four disable bits and two write-one-to-clear detected flags. One flag is set when a command completes and the other when an arbitration error is detected. Bit 0 of the locator is the command source. Bit k+1 is slot k. The locator is recomputed combinationally from the stored state, so it reflects every register write and every event as soon as the state register takes it.

The interrupt is delivered in one of two ways. In level mode `irq_o` follows the computed level. In message mode `msg_o` pulses for one cycle whenever the computed level differs from the last recorded level. The block records the level every cycle. A restore strobe clears the recorded level, so a condition that is still pending is signalled again.

Top module: `hp_loc_agg`

## Requirements
- R1: After reset the control word (address 0) reads 0x0000000F. Every slot word reads 0x00007F00, meaning all latches are clear and all seven mask bits are set. `locator_o`, `irq_o` and `msg_o` are all 0.
- R2: The slot word for slot k is at address k+2. Bits 4:0 are the latches and bits 14:8 are the mask. Bits 7:5 and 15 read 0. Byte enable 1 writes the mask from data bits 14:8. Byte enable 0 clears each latch bit whose data bit is 1, and latch bits written with 0 keep their value.
- R3: A 1 on `slot_evt_i[5k+b]` sets latch bit b of slot k, whatever the mask holds.
- R4: Locator bit k+1 is 1 exactly when slot k has a latch bit set whose mask bit (bits 4:0) is clear. Mask bits 5 and 6 do not affect the locator.
- R5: Locator bit 0 is 1 exactly when control bit 16 (command detected) is 1 and control bit 2 (command interrupt disable) is 0.
- R6: Control bits 3:0 are written with byte enable 0. Bits 16 and 17 are set by `cmd_done_i` and `arb_det_i` respectively, and are cleared by writing a 1 with byte enable 2. All other control bits read 0.
- R7: The level is 1 when control bit 0 is 0 and the locator is non-zero. `irq_o` equals the level when `msg_mode_i` is 0 and is 0 when `msg_mode_i` is 1.
- R8: In message mode `msg_o` is high for exactly one cycle after the level changes relative to the level recorded on the previous cycle. The level is recorded every cycle.
- R9: `restore_i` clears the recorded level, so a level that stays at 1 produces a new `msg_o` pulse on the following cycle.
- R10: When a hardware set and a software clear hit the same flag in the same cycle, the set wins.
- R11: Address 1 reads the locator. Writes to address 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (6) | Write word address |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Write byte enables |
| rd_addr_i | input | ADDR_W (6) | Read word address |
| rd_data_o | output | 32 | Read data, combinational |
| slot_evt_i | input | NUM_SLOTS*5 (155) | Per-slot event set pulses, 5 bits per slot |
| cmd_done_i | input | 1 | Sets the command-detected flag |
| arb_det_i | input | 1 | Sets the arbitration-detected flag |
| msg_mode_i | input | 1 | 1 selects message-style delivery |
| restore_i | input | 1 | Clears the recorded level |
| locator_o | output | 32 | Interrupt locator word |
| irq_o | output | 1 | Level interrupt |
| msg_o | output | 1 | One-cycle message event |

## Verification
The hardest cases to reach from the ports are the edge-triggered behaviours. One is a one-cycle message pulse that must appear on the cycle after the level changes and be gone one cycle later. The other is a hardware set landing in the same cycle as a software clear of the same flag. The stimulus raises `cmd_done_i` and a write-one-to-clear of bit 16 in the same cycle, and it samples `msg_o` on two consecutive cycles after each level change and after a restore strobe. The highest slot, and the mask bits that do not gate the interrupt, are exercised separately to cover the locator's upper boundary and its gating.

// File: rtl/hp_loc_pkg.sv
package hp_loc_pkg;
  localparam int EVT_W       = 5;
  localparam int MASK_W      = 7;
  localparam int DIS_W       = 4;
  localparam int DET_W       = 2;
  localparam int LOC_W       = 32;
  localparam int SLOT_BASE   = 2;
  localparam int IRQ_DIS_BIT = 0;
  localparam int CMD_DIS_BIT = 2;
  localparam int CMD_DET_BIT = 16;
  localparam logic [MASK_W-1:0] MASK_RST = '1;
  localparam logic [DIS_W-1:0]  DIS_RST  = '1;
endpackage

// File: rtl/hp_loc_slot.sv
module hp_loc_slot import hp_loc_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        be_i,
  input  logic [EVT_W-1:0]  clr_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [EVT_W-1:0]  evt_i,
  output logic [EVT_W-1:0]  latch_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              hit_o
);
  logic [EVT_W-1:0]  latch_q, latch_d;
  logic [MASK_W-1:0] mask_q, mask_d;

  always_comb begin
    latch_d = latch_q;
    mask_d  = mask_q;
    if (wr_i && be_i[0]) latch_d = latch_q & ~clr_i;
    if (wr_i && be_i[1]) mask_d  = mask_i;
    latch_d = latch_d | evt_i;  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      mask_q  <= MASK_RST;
    end else begin
      latch_q <= latch_d;
      mask_q  <= mask_d;
    end
  end

  assign latch_o = latch_q;
  assign mask_o  = mask_q;
  assign hit_o   = |(latch_q & ~mask_q[EVT_W-1:0]);
endmodule

// File: rtl/hp_loc_ctrl.sv
module hp_loc_ctrl import hp_loc_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             be0_i,
  input  logic             be2_i,
  input  logic [DIS_W-1:0] dis_i,
  input  logic [DET_W-1:0] det_clr_i,
  input  logic             cmd_set_i,
  input  logic             arb_set_i,
  output logic [LOC_W-1:0] ctrl_o
);
  logic [DIS_W-1:0] dis_q, dis_d;
  logic [DET_W-1:0] det_q, det_d;

  always_comb begin
    dis_d = dis_q;
    det_d = det_q;
    if (wr_i && be0_i) dis_d = dis_i;
    if (wr_i && be2_i) det_d = det_q & ~det_clr_i;
    det_d = det_d | {arb_set_i, cmd_set_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= DIS_RST;
      det_q <= '0;
    end else begin
      dis_q <= dis_d;
      det_q <= det_d;
    end
  end

  assign ctrl_o = {{(LOC_W-CMD_DET_BIT-DET_W){1'b0}}, det_q,
                   {(CMD_DET_BIT-DIS_W){1'b0}}, dis_q};
endmodule

// File: rtl/hp_loc_irq.sv
module hp_loc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic msg_mode_i,
  input  logic restore_i,
  output logic irq_o,
  output logic msg_o
);
  logic rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rec_q <= 1'b0;
    else if (restore_i) rec_q <= 1'b0;
    else                rec_q <= level_i;
  end

  assign irq_o = level_i & ~msg_mode_i;
  assign msg_o = msg_mode_i & (level_i ^ rec_q);
endmodule

// File: rtl/hp_loc_agg.sv
module hp_loc_agg import hp_loc_pkg::*; #(
  parameter int NUM_SLOTS = 31,
  parameter int ADDR_W    = $clog2(NUM_SLOTS + SLOT_BASE)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [31:0]                wr_data_i,
  input  logic [3:0]                 wr_be_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [31:0]                rd_data_o,
  input  logic [NUM_SLOTS*EVT_W-1:0] slot_evt_i,
  input  logic                       cmd_done_i,
  input  logic                       arb_det_i,
  input  logic                       msg_mode_i,
  input  logic                       restore_i,
  output logic [LOC_W-1:0]           locator_o,
  output logic                       irq_o,
  output logic                       msg_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] LOC_ADDR  = ADDR_W'(1);

  logic [LOC_W-1:0]  ctrl_q;
  logic [LOC_W-1:0]  loc_w;
  logic [NUM_SLOTS-1:0] hit_w;
  logic [EVT_W-1:0]  latch_w [NUM_SLOTS];
  logic [MASK_W-1:0] mask_w  [NUM_SLOTS];
  logic              level_w;
  logic              unused_ok;

  assign unused_ok = ^{wr_data_i[31:18], wr_data_i[15], wr_data_i[7:5], wr_be_i[3]};

  hp_loc_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i && (wr_addr_i == CTRL_ADDR)),
    .be0_i     (wr_be_i[0]),
    .be2_i     (wr_be_i[2]),
    .dis_i     (wr_data_i[DIS_W-1:0]),
    .det_clr_i (wr_data_i[CMD_DET_BIT +: DET_W]),
    .cmd_set_i (cmd_done_i),
    .arb_set_i (arb_det_i),
    .ctrl_o    (ctrl_q)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    hp_loc_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (wr_addr_i == ADDR_W'(SLOT_BASE + k))),
      .be_i    (wr_be_i[1:0]),
      .clr_i   (wr_data_i[EVT_W-1:0]),
      .mask_i  (wr_data_i[8 +: MASK_W]),
      .evt_i   (slot_evt_i[k*EVT_W +: EVT_W]),
      .latch_o (latch_w[k]),
      .mask_o  (mask_w[k]),
      .hit_o   (hit_w[k])
    );
  end

  // locator: bit 0 command source, bit k+1 slot k
  always_comb begin
    loc_w = '0;
    loc_w[0] = ctrl_q[CMD_DET_BIT] & ~ctrl_q[CMD_DIS_BIT];
    loc_w[NUM_SLOTS:1] = hit_w;
  end

  assign level_w   = ~ctrl_q[IRQ_DIS_BIT] & (|loc_w);
  assign locator_o = loc_w;

  hp_loc_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level_w),
    .msg_mode_i (msg_mode_i),
    .restore_i  (restore_i),
    .irq_o      (irq_o),
    .msg_o      (msg_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CTRL_ADDR) rd_data_o = ctrl_q;
    if (rd_addr_i == LOC_ADDR)  rd_data_o = loc_w;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (rd_addr_i == ADDR_W'(SLOT_BASE + k))
        rd_data_o = {16'h0, 1'b0, mask_w[k], 3'b0, latch_w[k]};
    end
  end
endmodule

// File: rtl/hp_loc_chk.sv
module hp_loc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        irq_o,
  input logic        msg_o,
  input logic        msg_mode_i,
  input logic        restore_i,
  input logic        cmd_done_i,
  input logic [31:0] locator_o,
  input logic [31:0] ctrl_i
);
  assert_cmd_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locator_o[0] |-> (ctrl_i[16] && !ctrl_i[2]));

  assert_irq_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((locator_o != 32'h0) && !msg_mode_i));

  assert_irq_dis_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[0] |-> !irq_o);

  assert_one_shot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_o |=> (!msg_o || !$stable(locator_o) || !$stable(ctrl_i) ||
               $past(restore_i) || !$stable(msg_mode_i)));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i |=> ctrl_i[16]);
endmodule

bind hp_loc_agg hp_loc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .msg_o      (msg_o),
  .msg_mode_i (msg_mode_i),
  .restore_i  (restore_i),
  .cmd_done_i (cmd_done_i),
  .locator_o  (locator_o),
  .ctrl_i     (ctrl_q)
);

// File: tb/hp_loc_agg_tb_top.sv
module hp_loc_agg_tb_top;
  localparam int NS = 31;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0] wr_be_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [NS*5-1:0] slot_evt_i = '0;
  logic cmd_done_i = 1'b0;
  logic arb_det_i = 1'b0;
  logic msg_mode_i = 1'b0;
  logic restore_i = 1'b0;
  logic [31:0] locator_o;
  logic irq_o, msg_o;

  always #10 clk = ~clk;

  hp_loc_agg dut_i (.clk_i(clk), .*);

  typedef struct {
    int          sel;  // 0 read data, 1 locator, 2 irq, 3 msg
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int pending = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // monitor: one expected item per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = rd_data_o;
        1: act = locator_o;
        2: act = {31'h0, irq_o};
        default: act = {31'h0, msg_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=0x%08h expected=0x%08h", it.req, it.sel, act, it.exp);
      end
      pending--;
    end
  end

  task automatic chk(int sel, logic [AW-1:0] addr, logic [31:0] exp, string req);
    item_t it;
    rd_addr_i = addr;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
    pending++;
    wait (pending == 0);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be);
    @(posedge clk); #1;
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; wr_be_i = be;
    @(posedge clk); #1;
    wr_en_i = 1'b0; wr_be_i = '0;
  endtask

  task automatic evt(int slot, logic [4:0] bits);
    @(posedge clk); #1;
    slot_evt_i[slot*5 +: 5] = bits;
    @(posedge clk); #1;
    slot_evt_i = '0;
  endtask

  task automatic pulse_cmd(bit arb);
    @(posedge clk); #1;
    if (arb) arb_det_i = 1'b1; else cmd_done_i = 1'b1;
    @(posedge clk); #1;
    arb_det_i = 1'b0; cmd_done_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk(0, 0, 32'h0000000F, "R1 ctrl reset");
    chk(0, 2, 32'h00007F00, "R1 slot0 reset");
    chk(0, 32, 32'h00007F00, "R1 slot30 reset");
    chk(1, 0, 32'h0, "R1 locator reset");
    chk(2, 0, 32'h0, "R1 irq reset");
    chk(3, 0, 32'h0, "R1 msg reset");

    // R3 event while masked
    evt(0, 5'h04);
    chk(0, 2, 32'h00007F04, "R3 latch set while masked");
    chk(1, 0, 32'h0, "R4 masked event hidden");

    // R2/R4 unmask slot 0
    wr(2, 32'h0, 4'b0010);
    chk(0, 2, 32'h00000004, "R2 mask write");
    chk(1, 0, 32'h00000002, "R4 slot0 locator bit1");
    chk(2, 0, 32'h0, "R7 global disable holds irq");

    // R7 enable interrupt
    wr(0, 32'h0000000E, 4'b0001);
    chk(0, 0, 32'h0000000E, "R6 disable bits write");
    chk(2, 0, 32'h1, "R7 irq asserted");

    // R2 W1C with zero on set bit keeps it; mask bit7 not writable
    wr(2, 32'h0000FF1B, 4'b0011);
    chk(0, 2, 32'h00007F04, "R2 partial clear and mask width");
    chk(1, 0, 32'h0, "R4 remasked");
    chk(2, 0, 32'h0, "R7 irq drops");

    // R2 clear latch, R4 mask bits 5,6 ignored
    wr(2, 32'h00006004, 4'b0011);
    chk(0, 2, 32'h00006000, "R2 latch cleared");
    evt(0, 5'h01);
    chk(1, 0, 32'h00000002, "R4 mask bits 5 and 6 ignored");
    wr(2, 32'h00000001, 4'b0001);
    chk(1, 0, 32'h0, "R2 latch clear to zero");

    // R4 last slot
    wr(32, 32'h0, 4'b0010);
    evt(30, 5'h10);
    chk(1, 0, 32'h80000000, "R4 slot30 locator bit31");
    chk(2, 0, 32'h1, "R7 irq from last slot");
    chk(0, 1, 32'h80000000, "R11 locator read");

    // R11 locator not writable
    wr(1, 32'hFFFFFFFF, 4'hF);
    chk(0, 1, 32'h80000000, "R11 locator write ignored");
    chk(0, 0, 32'h0000000E, "R11 ctrl untouched");

    // R6/R5 command detected
    pulse_cmd(1'b0);
    chk(0, 0, 32'h0001000E, "R6 cmd detected set");
    chk(1, 0, 32'h80000000, "R5 cmd source disabled");
    wr(0, 32'h0000000A, 4'b0001);
    chk(1, 0, 32'h80000001, "R5 cmd source bit0");

    // R10 set and clear in same cycle
    @(posedge clk); #1;
    cmd_done_i = 1'b1;
    wr_en_i = 1'b1; wr_addr_i = 0; wr_data_i = 32'h00010000; wr_be_i = 4'b0100;
    @(posedge clk); #1;
    cmd_done_i = 1'b0; wr_en_i = 1'b0; wr_be_i = '0;
    chk(0, 0, 32'h0001000A, "R10 set wins over clear");
    wr(0, 32'h00010000, 4'b0100);
    chk(0, 0, 32'h0000000A, "R6 cmd detected cleared");
    chk(1, 0, 32'h80000000, "R5 cmd source gone");

    // R6 arbitration flag
    pulse_cmd(1'b1);
    chk(0, 0, 32'h0002000A, "R6 arb detected set");
    wr(0, 32'hFFFC0000, 4'b0100);
    chk(0, 0, 32'h0002000A, "R6 zero writes keep flag");
    wr(0, 32'h00020000, 4'b0100);
    chk(0, 0, 32'h0000000A, "R6 arb detected cleared");

    // R7/R8 message mode
    @(posedge clk); #1 msg_mode_i = 1'b1;
    chk(2, 0, 32'h0, "R7 irq quiet in message mode");
    chk(3, 0, 32'h0, "R8 no event without change");
    wr(32, 32'h00000010, 4'b0001);
    chk(3, 0, 32'h1, "R8 event on falling level");
    @(posedge clk);
    chk(3, 0, 32'h0, "R8 single cycle pulse");
    evt(30, 5'h10);
    chk(3, 0, 32'h1, "R8 event on rising level");
    @(posedge clk);
    chk(3, 0, 32'h0, "R8 pulse ends");

    // R9 restore re-arms
    @(posedge clk); #1 restore_i = 1'b1;
    @(posedge clk); #1 restore_i = 1'b0;
    chk(3, 0, 32'h1, "R9 restore re-signals");
    @(posedge clk);
    chk(3, 0, 32'h0, "R9 restore pulse ends");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule